// File: doc/BRIEF.md
# Receive Frame Length Counter

This block counts the bytes of a serial-link receive frame and keeps the total for a host to read. A one-cycle `byteValid` strobe marks each received byte, and a one-cycle `frameEnd` strobe marks the end of the frame. At the end of the frame the block captures the byte total and an overflow flag, and it raises a message-end indication (`rmeIrq`). The captured values stay frozen until the host answers with `hostAck`.

The 12-bit total is split across two read-only registers, which the host reads through a synchronous read port. Address 0 selects the low byte. Address 1 selects the upper four count bits, with the overflow flag in bit 7. The count wraps modulo 4096, so its five lowest bits always give the number of bytes in the final partial block of a 32-byte receive buffer. The overflow flag marks any frame that carried more than 4096 bytes.

Top module: `rxLenCounter`

## Requirements
- R1: After reset `rmeIrq` and `lenOvf` are 0, and reads at address 0 and at address 1 both return 8'h00.
- R2: A `frameEnd` pulse captures the number of `byteValid` pulses of the frame. A byte strobed in the same cycle as `frameEnd` belongs to the ending frame. `rmeIrq` is 1 from the cycle after the `frameEnd` pulse.
- R3: A read with `rdEn`=1 puts data on `rdData` in the next cycle. Address 0 returns count bits 7..0. Address 1 returns count bits 11..8 in bits 3..0, the overflow flag in bit 7, and zeros in bits 6..4. While `rdEn`=0, `rdData` holds its value.
- R4: The overflow flag is set when a frame carries 4097 or more bytes. A frame of exactly 4096 bytes does not set it.
- R5: The captured count equals the byte total modulo 4096, so its bits 4..0 equal the total modulo 32. For example, 4096 bytes read as 0 and 4097 bytes read as 1.
- R6: From capture until `hostAck`, the captured count, the overflow flag and `rmeIrq` do not change, even when new bytes arrive.
- R7: `hostAck` without `frameEnd` clears `rmeIrq`, `lenOvf` and the captured count to 0 from the next cycle.
- R8: The running count restarts after each `frameEnd`. It also restarts on `hostAck`, and a byte strobed in the `hostAck` cycle is counted as the first byte of the new count.
- R9: When `frameEnd` and `hostAck` occur in the same cycle, the old capture is released and the ending frame is captured.
- R10: A `frameEnd` that arrives while a capture is pending and `hostAck` is absent is dropped. The pending values stay as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | One byte received this cycle |
| frameEnd | input | 1 | Current frame ends this cycle |
| hostAck | input | 1 | Host acknowledge; releases the capture |
| rdEn | input | 1 | Register read request |
| rdAddr | input | 1 | 0 selects the low count register, 1 selects the high register |
| rdData | output | 8 | Read data, valid the cycle after `rdEn` |
| rmeIrq | output | 1 | Message-end indication, high while a capture is pending |
| lenOvf | output | 1 | Captured overflow flag |

## Verification
The bench builds the block with its default 12-bit count and 8-bit register width. With these values the overflow and wrap boundary sits at 4096 bytes, and the bench reaches it directly by sending frames of exactly 4096 and 4097 bytes. Random frames of up to 300 bytes, sent with random gaps and a random choice of whether the last byte shares the end strobe, check the modulo-32 remainder and the split across the two registers. Directed cases cover an end strobe while a capture is pending, a byte in the acknowledge cycle, and an acknowledge in the same cycle as the end strobe.

// File: rtl/rxLenPkg.sv
package rxLenPkg;
  // Strobes passed from the control unit to the datapath each cycle
  typedef struct packed {
    logic clrRun;   // restart the running count before this cycle's byte
    logic incRun;   // count one byte
    logic endFrame; // running count restarts after this cycle
    logic latch;    // capture the running result
    logic clrLatch; // release the capture
  } rxLenStrb_t;
endpackage

// File: rtl/rxLenCtrl.sv
module rxLenCtrl
  import rxLenPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic       frameEnd,
  input  logic       hostAck,
  output rxLenStrb_t strb,
  output logic       rmeIrq
);
  logic pending;
  logic doLatch;

  // A new capture is taken only when no capture is pending,
  // or when the pending one is released in this same cycle.
  assign doLatch = frameEnd && (!pending || hostAck);

  always_comb begin
    strb.clrRun   = hostAck && !frameEnd;
    strb.incRun   = byteValid;
    strb.endFrame = frameEnd;
    strb.latch    = doLatch;
    strb.clrLatch = hostAck && !doLatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        pending <= 1'b0;
    else if (doLatch) pending <= 1'b1;
    else if (hostAck) pending <= 1'b0;
  end

  assign rmeIrq = pending;
endmodule

// File: rtl/rxLenDatapath.sv
module rxLenDatapath
  import rxLenPkg::*;
#(
  parameter int CNT_W = 12,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxLenStrb_t       strb,
  input  logic             rdEn,
  input  logic             rdAddr,
  output logic [REG_W-1:0] rdData,
  output logic             lenOvf
);
  localparam int HI_W = CNT_W - REG_W;

  logic [CNT_W-1:0] runCnt, baseCnt, sumCnt, latCnt;
  logic [CNT_W:0]   sumFull;
  logic             runWrap, baseWrap, sumWrap;
  logic             runOvf, baseOvf, sumOvf, latOvf;
  logic [REG_W-1:0] hiWord, loWord;

  // Result for this cycle, starting from the running state or from zero
  always_comb begin
    baseCnt  = strb.clrRun ? '0   : runCnt;
    baseWrap = strb.clrRun ? 1'b0 : runWrap;
    baseOvf  = strb.clrRun ? 1'b0 : runOvf;
    sumFull  = {1'b0, baseCnt} + (CNT_W+1)'(strb.incRun);
    sumCnt   = sumFull[CNT_W-1:0];
    sumWrap  = baseWrap | sumFull[CNT_W];
    // one byte more after a full wrap means the limit is passed
    sumOvf   = baseOvf | (strb.incRun & baseWrap);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.endFrame) begin
      runCnt  <= '0;
      runWrap <= 1'b0;
      runOvf  <= 1'b0;
    end else begin
      runCnt  <= sumCnt;
      runWrap <= sumWrap;
      runOvf  <= sumOvf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrLatch) begin
      latCnt <= '0;
      latOvf <= 1'b0;
    end else if (strb.latch) begin
      latCnt <= sumCnt;
      latOvf <= sumOvf;
    end
  end

  always_comb begin
    loWord = latCnt[REG_W-1:0];
    hiWord = '0;
    hiWord[HI_W-1:0] = latCnt[CNT_W-1:REG_W];
    hiWord[REG_W-1]  = latOvf;
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdAddr ? hiWord : loWord;
  end

  assign lenOvf = latOvf;
endmodule

// File: rtl/rxLenCounter.sv
module rxLenCounter
  import rxLenPkg::*;
#(
  parameter int CNT_W = 12,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic             frameEnd,
  input  logic             hostAck,
  input  logic             rdEn,
  input  logic             rdAddr,
  output logic [REG_W-1:0] rdData,
  output logic             rmeIrq,
  output logic             lenOvf
);
  rxLenStrb_t strb;

  rxLenCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .frameEnd(frameEnd),
    .hostAck(hostAck), .strb(strb), .rmeIrq(rmeIrq)
  );

  rxLenDatapath #(.CNT_W(CNT_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .lenOvf(lenOvf)
  );
endmodule

// File: rtl/rxLenCounterChk.sv
module rxLenCounterChk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameEnd,
  input logic             hostAck,
  input logic             rdEn,
  input logic             rdAddr,
  input logic [REG_W-1:0] rdData,
  input logic             rmeIrq,
  input logic             lenOvf
);
  a_r2_irq_after_end: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> rmeIrq);

  a_r6_capture_held: assert property (@(posedge clk) disable iff (!rstN)
    rmeIrq && !hostAck |=> rmeIrq && $stable(lenOvf));

  a_r7_ack_release: assert property (@(posedge clk) disable iff (!rstN)
    hostAck && !frameEnd |=> !rmeIrq && !lenOvf);

  a_r4_ovf_needs_capture: assert property (@(posedge clk) disable iff (!rstN)
    lenOvf |-> rmeIrq);

  a_r3_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  a_r3_high_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && rdAddr |=> rdData[REG_W-2:4] == '0);
endmodule

bind rxLenCounter rxLenCounterChk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .hostAck(hostAck),
  .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rmeIrq(rmeIrq),
  .lenOvf(lenOvf)
);

// File: tb/rxLenCounter_tb.sv
`timescale 1ns/1ps
module rxLenCounter_tb;
  localparam int CNT_W = 12;
  localparam int REG_W = 8;
  localparam int MODV  = 1 << CNT_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0, frameEnd = 1'b0, hostAck = 1'b0;
  logic rdEn = 1'b0, rdAddr = 1'b0;
  logic [REG_W-1:0] rdData;
  logic rmeIrq, lenOvf;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rxLenCounter #(.CNT_W(CNT_W), .REG_W(REG_W)) u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .frameEnd(frameEnd),
    .hostAck(hostAck), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .rmeIrq(rmeIrq), .lenOvf(lenOvf)
  );

  function automatic int expLow(int n);
    return (n % MODV) & 8'hFF;
  endfunction
  function automatic int expHigh(int n);
    return ((n % MODV) >> REG_W) | ((n > MODV) ? 8'h80 : 0);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle with the given strobes, ends on a falling edge
  task automatic drive(bit bv, bit fe, bit ack);
    byteValid = bv; frameEnd = fe; hostAck = ack;
    @(negedge clk);
    byteValid = 0; frameEnd = 0; hostAck = 0;
  endtask

  task automatic readReg(bit addr, output int val);
    rdEn = 1; rdAddr = addr;
    @(negedge clk);
    rdEn = 0;
    val = int'(rdData);
  endtask

  task automatic checkCapture(int n, string req);
    int lo, hi;
    check(rmeIrq == 1'b1, req, rmeIrq, 1);
    check(lenOvf == (n > MODV), req, lenOvf, n > MODV);
    readReg(0, lo);
    check(lo == expLow(n), req, lo, expLow(n));
    readReg(1, hi);
    check(hi == expHigh(n), req, hi, expHigh(n));
  endtask

  // n bytes; optional random gaps; last byte optionally shares frameEnd
  task automatic sendFrame(int n, bit gaps, bit endOnLast, bit ackAtEnd);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) drive(0, 0, 0);
      drive(1, endOnLast && (i == n-1), ackAtEnd && endOnLast && (i == n-1));
    end
    if (!endOnLast || n == 0) drive(0, 1, ackAtEnd);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int v, lo, hi, seedDummy;
    seedDummy = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check(rmeIrq == 0, "R1", rmeIrq, 0);
    check(lenOvf == 0, "R1", lenOvf, 0);
    readReg(0, v); check(v == 0, "R1", v, 0);
    readReg(1, v); check(v == 0, "R1", v, 0);

    // R2/R3: five bytes, separate end strobe
    sendFrame(5, 0, 0, 0);
    checkCapture(5, "R2");
    // R3 hold while rdEn low
    repeat (4) drive(0, 0, 0);
    check(rdData == 8'h80 * 0 + expHigh(5), "R3", rdData, expHigh(5));

    // R6/R10: bytes and a second end while pending
    repeat (10) drive(1, 0, 0);
    drive(1, 1, 0);
    checkCapture(5, "R10");
    repeat (3) drive(1, 0, 0);
    checkCapture(5, "R6");

    // R8: ack with a byte in the same cycle, then two bytes
    drive(1, 0, 1);
    // R7 released
    check(rmeIrq == 0, "R7", rmeIrq, 0);
    check(lenOvf == 0, "R7", lenOvf, 0);
    readReg(0, v); check(v == 0, "R7", v, 0);
    sendFrame(2, 0, 0, 0);
    checkCapture(3, "R8");

    // R9: next frame ends together with the ack
    sendFrame(7, 1, 1, 1);
    checkCapture(7, "R9");
    drive(0, 0, 1);

    // empty frame (R2)
    drive(0, 1, 0);
    checkCapture(0, "R2");
    drive(0, 0, 1);

    // R4/R5 boundary: exactly 4096 bytes
    sendFrame(MODV, 0, 1, 0);
    checkCapture(MODV, "R4");
    drive(0, 0, 1);
    // 4097 bytes sets overflow, count reads 1
    sendFrame(MODV + 1, 0, 0, 0);
    checkCapture(MODV + 1, "R4");
    check(lenOvf == 1, "R4", lenOvf, 1);
    drive(0, 0, 1);
    check(lenOvf == 0, "R7", lenOvf, 0);
    // 4100 with end on the last byte
    sendFrame(MODV + 4, 1, 1, 0);
    checkCapture(MODV + 4, "R5");
    drive(0, 0, 1);

    // R5 random frames
    for (int k = 0; k < 24; k++) begin
      int n;
      n = 1 + int'($urandom % 300);
      sendFrame(n, 1, ($urandom % 2) == 1, 0);
      readReg(0, lo);
      check((lo & 31) == (n % 32), "R5", lo & 31, n % 32);
      readReg(1, hi);
      check(hi == expHigh(n), "R3", hi, expHigh(n));
      drive(0, 0, 1);
      check(rmeIrq == 0, "R7", rmeIrq, 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule